// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

This block sits between a system interconnect and an SDRAM controller and decides which of up to four memory banks, if any, a request address falls into. Each bank is described by a 32-bit configuration word that packs an 8 MiB-aligned base address, a 3-bit size code and a valid bit. A single global enable sits above all banks. Turning it off unmaps every bank at once. Turning it on again brings back every bank whose word is still valid.

For each request the decoder returns a hit flag, the index of the chosen bank and the byte offset inside that bank, one clock after the request. On a miss the hit flag stays low so that the interconnect can answer with an error. The block also reports, every cycle, which banks are currently mapped.

A separate combinational helper turns a bank size given in MiB and a base address into a well-formed configuration word. Integration logic uses it to build the words that pre-load the banks at reset.

Top module: `sdram_bank_decoder`

## Requirements
- R1: While reset is high and on the first clock after it, rsp_valid, rsp_hit and mapped_o are all zero.
- R2: A configuration word holds the bank base in bits 31:23, so bases are aligned to 8 MiB. A mapped bank hits when the request address, with the bits below the bank size cleared, equals that base. On a hit, rsp_offset is the request address minus the base. Word bits 22:20 and 16:1 have no effect.
- R3: The size code sits in word bits 19:17. The bank size is 4 MiB shifted left by the code, so codes 0 to 6 give 4 MiB to 256 MiB. The last byte of a bank hits and the first byte past it does not.
- R4: A bank whose size code is 7 never hits and is never reported as mapped.
- R5: Word bit 0 is the bank valid bit. A bank whose valid bit is clear never hits.
- R6: While glob_en is low, no bank hits and mapped_o is zero. Raising glob_en again restores every bank whose word is still valid.
- R7: When several banks hit the same address, the one with the lowest index is reported.
- R8: When no bank hits, or when there is no request, rsp_hit is 0, and rsp_bank and rsp_offset are 0.
- R9: Outputs are registered with one cycle of latency. rsp_valid on a clock equals req_valid one clock earlier, and rsp_hit is only high together with rsp_valid.
- R10: For a bld_size_mib that is a power of two from 4 to 256, bld_ok is 1 and bld_word is: the code log2(size/4) in bits 19:17, OR bld_base bits 31:23, OR 1. Any other size gives bld_ok 0 and bld_word 0.
- R11: Bit i of mapped_o, one clock after its inputs, is 1 exactly when word i has its valid bit set, a size code other than 7, and glob_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_en | input | 1 | Global controller enable |
| bank_words | input | NUM_BANKS*32 | Bank configuration words; bank i occupies bits 32*i+31:32*i |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| rsp_valid | output | 1 | Registered copy of req_valid |
| rsp_hit | output | 1 | Request fell into a mapped bank |
| rsp_bank | output | IDX_W | Index of the selected bank |
| rsp_offset | output | 32 | Byte offset inside the selected bank |
| mapped_o | output | NUM_BANKS | Per-bank mapped flags |
| bld_size_mib | input | SIZE_W | Helper: bank size in MiB |
| bld_base | input | 32 | Helper: bank base address |
| bld_word | output | 32 | Helper: built configuration word |
| bld_ok | output | 1 | Helper: size was legal |

## Verification
The bench builds the block with NUM_BANKS = 4 and SIZE_W = 10. Four banks are enough to set up overlap chains in which the winner can be each bank index in turn, including the case where the lowest bank is invalid and a higher one takes over. A ten-bit helper size input lets the bench offer illegal sizes both above and below the legal range, such as 512 and 2 MiB, next to the seven legal ones.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

    localparam int WORD_W        = 32;
    localparam int BASE_LSB      = 23;
    localparam int CODE_LSB      = 17;
    localparam int CODE_W        = 3;
    localparam int MIN_SIZE_LOG2 = 22;
    localparam int MIN_SIZE_MIB  = 4;
    localparam int NUM_CODES     = 7;
    localparam logic [CODE_W-1:0] CODE_BAD = 3'd7;
    localparam logic [WORD_W-1:0] BASE_MASK =
        ~((WORD_W'(1) << BASE_LSB) - WORD_W'(1));

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [CODE_W-1:0] code;
        logic              valid;
    } bank_fields_t;

    typedef struct packed {
        logic              mapped;
        logic              hit;
        logic [WORD_W-1:0] offset;
    } bank_result_t;

    function automatic bank_fields_t unpack_word(input logic [WORD_W-1:0] w);
        bank_fields_t f;
        f.base  = w & BASE_MASK;
        f.code  = w[CODE_LSB +: CODE_W];
        f.valid = w[0];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] upper_mask(input logic [CODE_W-1:0] code);
        logic [WORD_W-1:0] span;
        span = (WORD_W'(1) << (MIN_SIZE_LOG2 + int'(code))) - WORD_W'(1);
        return ~span;
    endfunction

    function automatic logic [WORD_W-1:0] make_word(input logic [CODE_W-1:0] code,
                                                    input logic [WORD_W-1:0] base);
        logic [WORD_W-1:0] w;
        w = base & BASE_MASK;
        w[CODE_LSB +: CODE_W] = code;
        w[0] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sdram_dec_bank_match.sv
module sdram_dec_bank_match
    import sdram_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              glob_en,
    input  logic [WORD_W-1:0] addr,
    output bank_result_t      res
);

    bank_fields_t f;
    logic         size_ok;
    logic         region_eq;

    always_comb begin
        f         = unpack_word(word);
        size_ok   = (f.code != CODE_BAD);
        region_eq = ((addr & upper_mask(f.code)) == f.base);
        res.mapped = f.valid & glob_en & size_ok;
        res.hit    = res.mapped & region_eq;
        res.offset = addr - f.base;
    end

endmodule

// File: rtl/sdram_dec_prio_pick.sv
module sdram_dec_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     hits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sdram_dec_word_build.sv
module sdram_dec_word_build
    import sdram_dec_pkg::*;
#(
    parameter int SIZE_W = 10
) (
    input  logic [SIZE_W-1:0] size_mib,
    input  logic [WORD_W-1:0] base,
    output logic [WORD_W-1:0] word,
    output logic              ok
);

    logic [CODE_W-1:0] code;

    always_comb begin
        ok   = 1'b0;
        code = '0;
        for (int c = 0; c < NUM_CODES; c++) begin
            if (size_mib == SIZE_W'(MIN_SIZE_MIB << c)) begin
                ok   = 1'b1;
                code = CODE_W'(c);
            end
        end
        word = ok ? make_word(code, base) : '0;
    end

endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
    import sdram_dec_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SIZE_W    = 10,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        glob_en,
    input  logic [NUM_BANKS*WORD_W-1:0] bank_words,
    input  logic                        req_valid,
    input  logic [WORD_W-1:0]           req_addr,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic [IDX_W-1:0]            rsp_bank,
    output logic [WORD_W-1:0]           rsp_offset,
    output logic [NUM_BANKS-1:0]        mapped_o,
    input  logic [SIZE_W-1:0]           bld_size_mib,
    input  logic [WORD_W-1:0]           bld_base,
    output logic [WORD_W-1:0]           bld_word,
    output logic                        bld_ok
);

    bank_result_t           res   [NUM_BANKS];
    logic [NUM_BANKS-1:0]   hit_vec;
    logic [NUM_BANKS-1:0]   map_vec;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic [WORD_W-1:0]      win_off;
    logic                   take;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_dec_bank_match u_match (
            .word    (bank_words[b*WORD_W +: WORD_W]),
            .glob_en (glob_en),
            .addr    (req_addr),
            .res     (res[b])
        );
        assign hit_vec[b] = res[b].hit;
        assign map_vec[b] = res[b].mapped;
    end

    sdram_dec_prio_pick #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_pick (
        .hits  (hit_vec),
        .found (any_hit),
        .idx   (win_idx)
    );

    always_comb begin
        win_off = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (win_idx == IDX_W'(i)) win_off = res[i].offset;
        end
    end

    assign take = req_valid & any_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_bank   <= '0;
            rsp_offset <= '0;
            mapped_o   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_hit    <= take;
            rsp_bank   <= take ? win_idx : '0;
            rsp_offset <= take ? win_off : '0;
            mapped_o   <= map_vec;
        end
    end

    sdram_dec_word_build #(.SIZE_W(SIZE_W)) u_build (
        .size_mib (bld_size_mib),
        .base     (bld_base),
        .word     (bld_word),
        .ok       (bld_ok)
    );

endmodule

// File: rtl/sdram_bank_decoder_chk.sv
module sdram_bank_decoder_chk #(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 glob_en,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [IDX_W-1:0]     rsp_bank,
    input logic [31:0]          rsp_offset,
    input logic [NUM_BANKS-1:0] mapped_o,
    input logic [31:0]          bld_word,
    input logic                 bld_ok
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: outputs clear on the clock after a reset cycle
    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_clear_R1: assert (!rsp_valid && !rsp_hit && mapped_o == '0);
        end
    end

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_hit_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);
    assert_disabled_no_hit_R6: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> !rsp_hit);
    assert_disabled_unmapped_R6: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> (mapped_o == '0));
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_bank == '0 && rsp_offset == '0));
    assert_hit_is_mapped_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> mapped_o[rsp_bank]);
    assert_build_form_R10: assert property (@(posedge clk) disable iff (rst)
        bld_ok |-> (bld_word[0] && bld_word[19:17] != 3'd7 && bld_word[16:1] == '0));
    assert_build_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !bld_ok |-> (bld_word == '0));

endmodule

bind sdram_bank_decoder sdram_bank_decoder_chk #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .glob_en    (glob_en),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_bank   (rsp_bank),
    .rsp_offset (rsp_offset),
    .mapped_o   (mapped_o),
    .bld_word   (bld_word),
    .bld_ok     (bld_ok)
);

// File: tb/sdram_bank_decoder_tb_top.sv
module sdram_bank_decoder_tb_top;

    localparam int NB = 4;
    localparam int SW = 10;

    logic            clk = 1'b0;
    logic            rst;
    logic            glob_en;
    logic [NB*32-1:0] bank_words;
    logic            req_valid;
    logic [31:0]     req_addr;
    logic            rsp_valid;
    logic            rsp_hit;
    logic [1:0]      rsp_bank;
    logic [31:0]     rsp_offset;
    logic [NB-1:0]   mapped_o;
    logic [SW-1:0]   bld_size_mib;
    logic [31:0]     bld_base;
    logic [31:0]     bld_word;
    logic            bld_ok;

    int checks = 0;
    int failures = 0;
    logic [31:0] wm [NB];
    logic        en_m;

    always #5 clk = ~clk;

    sdram_bank_decoder #(.NUM_BANKS(NB), .SIZE_W(SW)) dut_i (
        .clk(clk), .rst(rst), .glob_en(glob_en), .bank_words(bank_words),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_bank(rsp_bank), .rsp_offset(rsp_offset),
        .mapped_o(mapped_o), .bld_size_mib(bld_size_mib), .bld_base(bld_base),
        .bld_word(bld_word), .bld_ok(bld_ok)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic bank_ok(input logic [31:0] w, input logic en);
        return w[0] && en && (w[19:17] != 3'b111);
    endfunction

    function automatic logic [NB-1:0] ref_mapped();
        logic [NB-1:0] m;
        for (int i = 0; i < NB; i++) m[i] = bank_ok(wm[i], en_m);
        return m;
    endfunction

    task automatic ref_decode(input logic [31:0] a, output logic h,
                              output logic [1:0] b, output logic [31:0] o);
        h = 0; b = 0; o = 0;
        for (int i = 0; i < NB; i++) begin
            logic [63:0] size;
            logic [63:0] base;
            base = {32'd0, wm[i] & 32'hFF80_0000};
            size = 64'h40_0000 << wm[i][19:17];
            if (!h && bank_ok(wm[i], en_m) && (({32'd0, a} & ~(size - 64'd1)) == base)) begin
                h = 1; b = 2'(i); o = a - base[31:0];
            end
        end
    endtask

    task automatic do_req(input logic v, input logic [31:0] a, input string req);
        logic eh; logic [1:0] eb; logic [31:0] eo;
        logic [NB-1:0] em;
        @(negedge clk);
        for (int i = 0; i < NB; i++) bank_words[i*32 +: 32] = wm[i];
        glob_en = en_m; req_valid = v; req_addr = a;
        ref_decode(a, eh, eb, eo);
        em = ref_mapped();
        if (!v) begin eh = 0; eb = 0; eo = 0; end
        @(posedge clk); #1;
        check(rsp_valid === v, req, "rsp_valid", 32'(rsp_valid), 32'(v));
        check(rsp_hit === eh, req, "rsp_hit", 32'(rsp_hit), 32'(eh));
        check(rsp_bank === eb, req, "rsp_bank", 32'(rsp_bank), 32'(eb));
        check(rsp_offset === eo, req, "rsp_offset", rsp_offset, eo);
        check(mapped_o === em, req, "mapped_o (R11)", 32'(mapped_o), 32'(em));
    endtask

    function automatic logic [31:0] mk(input int code, input logic [31:0] base, input logic v);
        return (base & 32'hFF80_0000) | (32'(code) << 17) | 32'(v);
    endfunction

    task automatic check_build(input int size, input logic [31:0] base);
        logic [31:0] ew; logic eo;
        eo = 0; ew = 0;
        for (int c = 0; c < 7; c++)
            if (size == (4 << c)) begin eo = 1; ew = mk(c, base, 1'b1); end
        bld_size_mib = SW'(size); bld_base = base;
        #1;
        check(bld_ok === eo, "R10", "bld_ok", 32'(bld_ok), 32'(eo));
        check(bld_word === ew, "R10", "bld_word", bld_word, ew);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd24681357);
        rst = 1; glob_en = 0; req_valid = 0; req_addr = 0; bank_words = '0;
        bld_size_mib = '0; bld_base = '0; en_m = 0;
        for (int i = 0; i < NB; i++) wm[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid === 0 && rsp_hit === 0, "R1", "rsp during reset", 32'(rsp_valid), 0);
        check(mapped_o === '0, "R1", "mapped during reset", 32'(mapped_o), 0);
        @(negedge clk); rst = 0;

        wm[0] = mk(4, 32'h0000_0000, 1);
        wm[1] = mk(3, 32'h0400_0000, 1);
        wm[2] = mk(0, 32'h0600_0000, 1);
        wm[3] = mk(7, 32'h0800_0000, 1);
        en_m = 1;
        do_req(1, 32'h0123_4567, "R2");
        do_req(1, 32'h0401_0000, "R2");
        do_req(1, 32'h063F_FFFF, "R3");
        do_req(1, 32'h0640_0000, "R3");
        do_req(1, 32'h05FF_FFFF, "R3");
        do_req(1, 32'h0800_0010, "R4");
        do_req(1, 32'hF000_0000, "R8");
        do_req(0, 32'h0000_0100, "R9");
        wm[0] = wm[0] | 32'h0071_FFFE;
        do_req(1, 32'h0000_0100, "R2");
        wm[1][0] = 1'b0;
        do_req(1, 32'h0401_0000, "R5");
        en_m = 0;
        do_req(1, 32'h0000_0100, "R6");
        en_m = 1;
        do_req(1, 32'h0000_0100, "R6");
        wm[1] = mk(6, 32'h0000_0000, 1);
        do_req(1, 32'h0000_0100, "R7");
        do_req(1, 32'h0500_0000, "R7");
        wm[0][0] = 1'b0;
        do_req(1, 32'h0000_0100, "R7");

        check_build(64, 32'h1234_5678);
        check_build(4, 32'hFFFF_FFFF);
        check_build(256, 32'h1000_0000);
        check_build(12, 32'h1000_0000);
        check_build(512, 32'h1000_0000);
        check_build(2, 32'h1000_0000);
        check_build(0, 32'h0);
        for (int c = 0; c < 7; c++) check_build(4 << c, $urandom);

        for (int it = 0; it < 400; it++) begin
            logic [31:0] a;
            int k;
            if (it % 40 == 0) begin
                for (int i = 0; i < NB; i++) begin
                    int code;
                    code = int'($urandom % 8);
                    wm[i] = mk(code, ($urandom % 16) << (22 + code), ($urandom % 4) != 0)
                            | ($urandom & 32'h0071_FFFE);
                end
                en_m = ($urandom % 5) != 0;
            end
            k = int'($urandom % NB);
            if ($urandom % 4 == 0) a = $urandom;
            else a = (wm[k] & 32'hFF80_0000)
                     + ($urandom & ((32'h0080_0000 << wm[k][19:17]) - 1));
            do_req(($urandom % 8) != 0, a, "R2/R3/R7 random");
        end

        finish_run();
    end

endmodule